// File: doc/BRIEF.md
# Receive Pad and FCS Stripper

This block is a byte-wide filter placed on the receive stream between a MAC and the consumer of its frames. It watches each frame go by and reads the two-byte length/type word that follows the destination and source addresses. If stripping is enabled for the frame and the word is a length (1500 or less), the block keeps only the header and the number of payload bytes the length announces. The pad bytes and the four trailing check bytes are removed and the end-of-frame marker moves onto the last kept byte. Type words and frames received with stripping disabled pass through untouched.

The stream passes through a four-byte delay line and then an output register. The block therefore decides the fate of a byte only once four more bytes of its frame have arrived, or once the frame has ended. A frame that ends early, before its announced payload plus check bytes are complete, loses exactly its last four bytes. The input must hold `in_valid` high on every cycle from the start-of-frame byte to the end-of-frame byte. A receive-enable input gates the acceptance of new frames.

The controller is a state machine with six states. IDLE waits between frames. HEADER covers bytes 0 to 13. PASS forwards the rest of an unmodified frame. TRIM forwards payload while stripping. DROP discards everything after the kept region. SKIP swallows a frame refused at its start. Transitions:
- A start-of-frame byte enters HEADER when receive is enabled, or SKIP when it is not.
- HEADER goes to TRIM on byte 13 if stripping applies, and to PASS otherwise.
- TRIM goes to DROP when the byte 17 + length arrives.
- Any state returns to IDLE on an end-of-frame byte.

Top module: `rx_pad_fcs_stripper`

## Requirements
- R1: With `strip_en` set on the first byte and a length/type value of 1500 or less, a frame of at least 18 + length bytes is forwarded as exactly its first 14 + length bytes, with `out_eof` on the last of them.
- R2: A frame whose length/type value is 1501 or more is forwarded with every byte unchanged, in order.
- R3: A frame whose first byte arrives with `strip_en` low is forwarded unchanged. The strip mode is taken only from that first byte, so later changes of `strip_en` within the frame have no effect.
- R4: A frame whose first byte arrives with `rx_en` low produces no output byte. Lowering `rx_en` in the middle of a frame lets that frame complete, and every later frame is refused until `rx_en` is high again at a start-of-frame.
- R5: The length/type value is big-endian: byte 12 of the frame is its high byte and byte 13 its low byte, counting from byte 0 at start-of-frame.
- R6: When stripping applies and the frame ends after at least 18 bytes but before 18 + length bytes, all bytes except the final four are forwarded, with `out_eof` on the last forwarded one.
- R7: A frame shorter than 18 bytes is forwarded unchanged whatever its length/type value.
- R8: Each forwarded frame shows `out_sof` on its first output byte only and `out_eof` on its last output byte only. `out_valid` is never high for a removed byte, and neither flag is high without `out_valid`.
- R9: A forwarded byte appears on the outputs five clock cycles after the cycle in which it is presented at the input.
- R10: While `rst_n` is low, `out_valid`, `out_sof` and `out_eof` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Accept frames starting while high |
| strip_en | input | 1 | Enable pad and check-byte removal, sampled on the first byte |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | `in_data` holds a byte this cycle |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_data | output | 8 | Forwarded byte |
| out_valid | output | 1 | `out_data` holds a byte this cycle |
| out_sof | output | 1 | First forwarded byte of a frame |
| out_eof | output | 1 | Last forwarded byte of a frame |

## Verification
The bench builds the block with its default parameters: an 11-bit byte index, a length limit of 1500 and a four-byte delay line. With these values a full 1518-byte frame whose length is exactly 1500 can run without the index saturating, next to a frame carrying 1501. The same settings reach the 18-byte edge, where the cut point and the tail flush fall on the same input byte, and a length that is read wrongly only if the two length bytes are swapped.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    localparam int BYTE_W      = 8;
    localparam int HDR_BYTES   = 14;  // destination + source + length/type
    localparam int LEN_HI_IDX  = 12;  // big-endian length/type high byte
    localparam int LEN_LO_IDX  = 13;  // big-endian length/type low byte

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PASS,
        ST_TRIM,
        ST_DROP,
        ST_SKIP
    } rxps_state_e;

    typedef struct packed {
        logic              valid;
        logic              sof;
        logic              eof;
        logic [BYTE_W-1:0] data;
    } rxps_beat_t;

    function automatic rxps_beat_t rxps_kill(input rxps_beat_t b);
        rxps_beat_t r;
        r       = b;
        r.valid = 1'b0;
        r.sof   = 1'b0;
        r.eof   = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/rxps_frame_ctrl.sv
module rxps_frame_ctrl
    import rxps_pkg::*;
#(
    parameter int IDX_W     = 11,
    parameter int MAX_LEN   = 1500,
    parameter int FCS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              strip_en,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [BYTE_W-1:0] in_data,
    output logic              keep,
    output logic              cut_eof,
    output logic              drop_tail,
    output logic              flush
);

    localparam int LEN_W      = 2 * BYTE_W;
    localparam int CMP_W      = ((IDX_W > LEN_W) ? IDX_W : LEN_W) + 1;
    localparam int FIRST_TAIL = HDR_BYTES + FCS_BYTES - 1;
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    rxps_state_e       st_q, st_d, cur_st;
    logic [IDX_W-1:0]  idx_q, cur_idx;
    logic              strip_q, cur_strip;
    logic [BYTE_W-1:0] hi_q;
    logic [LEN_W-1:0]  len_q, len_now;
    logic [CMP_W-1:0]  idx_ext, end_ext;
    logic              in_tail, at_end;

    // View of the byte on the input this cycle
    always_comb begin
        cur_st    = in_sof ? (rx_en ? ST_HDR : ST_SKIP) : st_q;
        cur_idx   = in_sof ? '0 : idx_q;
        cur_strip = in_sof ? strip_en : strip_q;
        len_now   = {hi_q, in_data};
        idx_ext   = CMP_W'(cur_idx);
        // Input index whose arrival releases the last kept byte from the line
        end_ext   = CMP_W'(FIRST_TAIL) + CMP_W'(len_q);
        in_tail   = idx_ext >= CMP_W'(FIRST_TAIL);
        at_end    = idx_ext == end_ext;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (in_eof) begin
                st_d = ST_IDLE;
            end else begin
                unique case (cur_st)
                    ST_HDR: begin
                        if (cur_idx == IDX_W'(LEN_LO_IDX))
                            st_d = (cur_strip && (len_now <= LEN_W'(MAX_LEN)))
                                 ? ST_TRIM : ST_PASS;
                        else
                            st_d = ST_HDR;
                    end
                    ST_TRIM: st_d = at_end ? ST_DROP : ST_TRIM;
                    default: st_d = cur_st;
                endcase
            end
        end
    end

    // State register and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            strip_q <= 1'b0;
            hi_q    <= '0;
            len_q   <= '0;
        end else begin
            st_q <= st_d;
            if (in_valid) begin
                idx_q <= (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
                if (in_sof)
                    strip_q <= strip_en;
                if (cur_st == ST_HDR && cur_idx == IDX_W'(LEN_HI_IDX))
                    hi_q <= in_data;
                if (cur_st == ST_HDR && cur_idx == IDX_W'(LEN_LO_IDX))
                    len_q <= len_now;
            end
        end
    end

    // Per-byte controls for the delay line
    always_comb begin
        keep      = in_valid && (cur_st == ST_HDR || cur_st == ST_PASS || cur_st == ST_TRIM);
        cut_eof   = in_valid && (cur_st == ST_TRIM) && in_tail && (at_end || in_eof);
        drop_tail = in_valid && (cur_st == ST_DROP);
        flush     = in_valid && in_eof &&
                    (((cur_st == ST_TRIM) && in_tail) || (cur_st == ST_DROP));
    end

endmodule

// File: rtl/rxps_fcs_delay.sv
module rxps_fcs_delay
    import rxps_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  rxps_beat_t in_beat,
    input  logic       flush,
    input  logic       cut_eof,
    input  logic       drop_tail,
    output rxps_beat_t out_beat
);

    rxps_beat_t out_q, out_d, tail_w;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        rxps_beat_t src;
        rxps_beat_t q;
        if (g == 0) begin : g_head
            assign src = in_beat;
        end else begin : g_link
            assign src = g_stage[g-1].q;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else
                q <= flush ? rxps_kill(src) : src;
        end
    end

    assign tail_w = g_stage[DEPTH-1].q;

    always_comb begin
        out_d = tail_w;
        if (drop_tail)
            out_d = rxps_kill(tail_w);
        else if (cut_eof)
            out_d.eof = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign out_beat = out_q;

endmodule

// File: rtl/rx_pad_fcs_stripper.sv
module rx_pad_fcs_stripper
    import rxps_pkg::*;
#(
    parameter int IDX_W     = 11,
    parameter int MAX_LEN   = 1500,
    parameter int FCS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              strip_en,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof
);

    logic       keep, cut_eof, drop_tail, flush;
    rxps_beat_t beat_in, beat_out;

    rxps_frame_ctrl #(
        .IDX_W     (IDX_W),
        .MAX_LEN   (MAX_LEN),
        .FCS_BYTES (FCS_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .strip_en  (strip_en),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_data   (in_data),
        .keep      (keep),
        .cut_eof   (cut_eof),
        .drop_tail (drop_tail),
        .flush     (flush)
    );

    always_comb begin
        beat_in.valid = keep;
        beat_in.sof   = keep && in_sof;
        beat_in.eof   = keep && in_eof;
        beat_in.data  = in_data;
    end

    rxps_fcs_delay #(
        .DEPTH (FCS_BYTES)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_beat   (beat_in),
        .flush     (flush),
        .cut_eof   (cut_eof),
        .drop_tail (drop_tail),
        .out_beat  (beat_out)
    );

    assign out_data  = beat_out.data;
    assign out_valid = beat_out.valid;
    assign out_sof   = beat_out.sof;
    assign out_eof   = beat_out.eof;

endmodule

// File: rtl/rxps_checker.sv
module rxps_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic in_valid,
    input logic in_sof,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof
);

    logic in_frame_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            in_frame_q <= 1'b0;
        else if (out_valid)
            in_frame_q <= !out_eof;
    end

    // R8: flags only ride on a valid byte
    a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);

    // R8: first byte after a frame end carries start-of-frame
    a_r8_sof_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_frame_q) |-> out_sof);

    // R8: no start-of-frame inside a frame
    a_r8_single_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_frame_q) |-> !out_sof);

    // R9: each output byte stems from an input byte five cycles earlier
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 5));

    // R4: a start refused by rx_en yields nothing five cycles later
    a_r4_refused_start: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !rx_en) |-> ##5 !out_valid);

endmodule

bind rx_pad_fcs_stripper rxps_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
);

// File: tb/rx_pad_fcs_stripper_tb.sv
`timescale 1ns/1ps
module rx_pad_fcs_stripper_tb;

    localparam int CAP = 4096;
    localparam int NVEC = 12;
    // {length/type, frame bytes, strip_en, expected output bytes}
    localparam logic [63:0] VEC [NVEC] = '{
        {16'd46,    16'd64,   16'd1, 16'd60},   // R1 minimal padded frame
        {16'd10,    16'd64,   16'd1, 16'd24},   // R1 heavy pad
        {16'd0,     16'd64,   16'd1, 16'd14},   // R1 zero length
        {16'd1500,  16'd1518, 16'd1, 16'd1514}, // R1 largest length
        {16'd1501,  16'd100,  16'd1, 16'd100},  // R2 just above limit
        {16'h0800,  16'd64,   16'd1, 16'd64},   // R2 type word
        {16'd10,    16'd64,   16'd0, 16'd64},   // R3 strip disabled
        {16'd40,    16'd50,   16'd1, 16'd46},   // R6 truncated frame
        {16'd2,     16'd17,   16'd1, 16'd17},   // R7 below 18 bytes
        {16'd0,     16'd18,   16'd1, 16'd14},   // R6 cut and end coincide
        {16'd1,     16'd18,   16'd1, 16'd14},   // R6 length beyond tail
        {16'h001E,  16'd300,  16'd1, 16'd44}    // R5 byte order
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       strip_en = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic [7:0] out_data;
    logic       out_valid, out_sof, out_eof;

    int checks = 0;
    int errors = 0;
    int got_n = 0;
    int cyc = 0;
    int sof_cyc = 0;
    logic [7:0] cap_data [CAP];
    logic       cap_sof  [CAP];
    logic       cap_eof  [CAP];
    int         cap_cyc  [CAP];

    always #4 clk = ~clk;

    rx_pad_fcs_stripper u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .strip_en  (strip_en),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eof   (out_eof)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_valid) begin
            cap_data[got_n % CAP] <= out_data;
            cap_sof[got_n % CAP]  <= out_sof;
            cap_eof[got_n % CAP]  <= out_eof;
            cap_cyc[got_n % CAP]  <= cyc;
            got_n <= got_n + 1;
        end
    end

    function automatic logic [7:0] byte_at(input int i, input int len, input int seed);
        if (i == 12) return len[15:8];
        if (i == 13) return len[7:0];
        return 8'((i * 7) + seed);
    endfunction

    function automatic string vec_tag(input int k);
        case (k)
            0, 1, 2, 3: return "R1";
            4, 5:       return "R2";
            6:          return "R3";
            7, 9, 10:   return "R6";
            8:          return "R7";
            default:    return "R5";
        endcase
    endfunction

    task automatic send_frame(input int len, input int total, input bit strip,
                              input bit strip_rest, input int seed, input int rx_off_at);
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == total - 1);
            in_data  = byte_at(i, len, seed);
            strip_en = (i == 0) ? strip : strip_rest;
            if (i == rx_off_at) rx_en = 1'b0;
            if (i == 0) sof_cyc = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_frame(input string tag, input int len, input int seed,
                               input int expn, input int base);
        int n;
        int bad;
        n = got_n - base;
        checks++;
        if (n != expn) begin
            errors++;
            $display("FAIL %s: output byte count %0d, expected %0d", tag, n, expn);
        end
        bad = -1;
        for (int j = 0; j < expn && j < n; j++) begin
            if (bad < 0 &&
                (cap_data[(base + j) % CAP] != byte_at(j, len, seed) ||
                 cap_sof[(base + j) % CAP] != (j == 0) ||
                 cap_eof[(base + j) % CAP] != (j == expn - 1)))
                bad = j;
        end
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s (R8 framing): byte %0d data/sof/eof %h/%b/%b, expected %h/%b/%b",
                     tag, bad, cap_data[(base + bad) % CAP], cap_sof[(base + bad) % CAP],
                     cap_eof[(base + bad) % CAP], byte_at(bad, len, seed),
                     (bad == 0), (bad == expn - 1));
        end
    endtask

    initial begin
        int base;
        // R10: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_eof !== 1'b0) begin
            errors++;
            $display("FAIL R10: valid/sof/eof %b/%b/%b, expected 0/0/0",
                     out_valid, out_sof, out_eof);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table walk
        for (int k = 0; k < NVEC; k++) begin
            base = got_n;
            send_frame(int'(VEC[k][63:48]), int'(VEC[k][47:32]), VEC[k][16], VEC[k][16],
                       k * 3 + 1, -1);
            check_frame($sformatf("%s vector %0d", vec_tag(k), k), int'(VEC[k][63:48]),
                        k * 3 + 1, int'(VEC[k][15:0]), base);
        end

        // R9: five-cycle latency on a pass-through frame
        base = got_n;
        send_frame(16'h0800, 20, 1'b1, 1'b1, 40, -1);
        check_frame("R9 frame", 16'h0800, 40, 20, base);
        checks++;
        if (cap_cyc[base % CAP] - sof_cyc != 5) begin
            errors++;
            $display("FAIL R9: latency %0d cycles, expected 5", cap_cyc[base % CAP] - sof_cyc);
        end

        // R3: strip_en dropped after the first byte has no effect
        base = got_n;
        send_frame(10, 64, 1'b1, 1'b0, 50, -1);
        check_frame("R3 late strip_en change", 10, 50, 24, base);

        // R7: single-byte frame
        base = got_n;
        send_frame(0, 1, 1'b1, 1'b1, 60, -1);
        check_frame("R7 single byte", 0, 60, 1, base);

        // R4: refused start
        rx_en = 1'b0;
        base = got_n;
        send_frame(46, 64, 1'b1, 1'b1, 70, -1);
        check_frame("R4 refused frame", 46, 70, 0, base);

        // R4: rx_en falls mid-frame, frame completes, next one refused
        rx_en = 1'b1;
        base = got_n;
        send_frame(46, 64, 1'b1, 1'b1, 80, 20);
        check_frame("R4 mid-frame disable", 46, 80, 60, base);
        base = got_n;
        send_frame(46, 64, 1'b1, 1'b1, 90, -1);
        check_frame("R4 still disabled", 46, 90, 0, base);
        rx_en = 1'b1;
        base = got_n;
        send_frame(46, 64, 1'b1, 1'b1, 100, -1);
        check_frame("R4 re-enabled", 46, 100, 60, base);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule